// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for an on-chip packet buffer that is split into a fixed number of equal packet slots. Each slot holds up to `PAGES_PER_SLOT` pages of 256 bytes. With the defaults there are four slots of 2 KB each, 8 KB in all. A host issues one command at a time through a small command port. The block hands out slot numbers, takes them back, and tracks two queues of slot numbers: one filled by the receive engine and one filled by the host for the transmit engine. The packet data memory and the MAC engines sit outside this block. Only the slot numbers pass through it.

An allocation request carries a page count minus one. For a frame of length L bytes, the host computes it as `((L & ~1) + 6) >> 8`. The 6 extra bytes hold the status, count and control words. A successful allocation returns the slot number and raises an allocation interrupt flag, which the host clears by writing a one. A failed allocation sets a failure flag instead. The free-memory output counts free slots, and each unit stands for 2 KB. After each accepted command a busy flag stays high for a fixed number of cycles. Commands that arrive during that window are dropped, so commands are serialized.

Top module: `pba_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the outputs are: `free_units` = NUM_SLOTS (4), `alloc_pkt` = 0, `alloc_fail` = 0, `alloc_int` = 0, `tx_int` = 0, `busy` = 0, `rx_empty` = 1 and `tx_empty` = 1.
- R2: `cmd_op` is 3 bits wide with these codes: 1 allocate, 2 reset-all, 3 release receive head, 4 free named slot, 5 enqueue. A command is accepted only when `cmd_valid` is high and `busy` is low. Codes 0, 6 and 7, and any command offered while `busy` is high, have no effect on any output.
- R3: An accepted command drives `busy` high for the next BUSY_CYCLES (3) cycles. A new command can be accepted at the edge after `busy` returns low.
- R4: An accepted allocate with a free slot and `cmd_pages` < PAGES_PER_SLOT (8) takes the lowest-numbered free slot. In the next cycle `alloc_pkt` shows that slot, `alloc_fail` is 0, `alloc_int` is 1 and `free_units` has dropped by one.
- R5: An allocate fails when no slot is free or `cmd_pages` >= PAGES_PER_SLOT. A failed allocate sets `alloc_fail` to 1, leaves `alloc_pkt` unchanged, takes no slot and does not raise `alloc_int`.
- R6: `int_ack` bit 0 clears `alloc_int` and bit 1 clears `tx_int`. If an acknowledge and a new set event occur in the same cycle, the set wins.
- R7: `free_units` always equals the number of free slots. One unit is 2 KB.
- R8: `rx_done` pushes `rx_pkt` into the receive queue. `rx_empty` and `rx_head` show the state of the queue and its oldest entry. A push to a full queue (NUM_SLOTS entries) is dropped.
- R9: A release command frees the slot named by `rx_head` and removes that entry from the queue. On an empty queue a release changes nothing except `busy`.
- R10: A free-named command frees slot `cmd_pkt`. Freeing a slot that is already free changes nothing.
- R11: An enqueue command pushes `cmd_pkt` into the transmit queue, which is shown by `tx_empty` and `tx_head`. A push to a full queue is dropped. `tx_done` on a non-empty transmit queue removes its head and sets `tx_int`. On an empty queue `tx_done` is ignored.
- R12: A reset-all command frees every slot and empties both queues. It overrides a `rx_done` or `tx_done` in the same cycle. It leaves `alloc_pkt`, `alloc_fail` and both interrupt flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_pages | input | REQ_W (4) | Allocation size as page count minus one |
| cmd_pkt | input | PKT_W (2) | Slot number for free-named and enqueue |
| int_ack | input | 2 | Write-one-to-clear: bit 0 allocation flag, bit 1 transmit flag |
| rx_done | input | 1 | Receive engine stores a slot number |
| rx_pkt | input | PKT_W (2) | Slot number from the receive engine |
| tx_done | input | 1 | Transmit engine finished the head entry |
| busy | output | 1 | Command in progress |
| alloc_pkt | output | PKT_W (2) | Slot number of the last successful allocation |
| alloc_fail | output | 1 | Last allocation failed |
| alloc_int | output | 1 | Allocation interrupt flag |
| tx_int | output | 1 | Transmit-complete interrupt flag |
| free_units | output | CNT_W (3) | Free slots, in 2 KB units |
| rx_empty | output | 1 | Receive queue holds no entry |
| rx_head | output | PKT_W (2) | Oldest receive queue entry |
| tx_empty | output | 1 | Transmit queue holds no entry |
| tx_head | output | PKT_W (2) | Oldest transmit queue entry |

## Verification
A slot bitmap that has gone wrong shows up first in `free_units`, which updates in the cycle after the faulty command. It shows up again at the next allocate, when a wrong slot number or a wrong failure flag appears one cycle later. A queue pointer or count that has gone wrong shows up as a wrong `rx_head`/`tx_head` or a wrong empty flag right after the next push or pop. A release that follows a corrupted receive queue frees the wrong slot, so the error reaches `free_units` and later allocations. The busy counter is compared every cycle, so a window that is too short or too long shows on the first command.

// File: rtl/pba_pkg.sv
package pba_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_WIPE    = 3'd2,
        OP_RELEASE = 3'd3,
        OP_FREE    = 3'd4,
        OP_QUEUE   = 3'd5
    } pba_op_e;

    typedef struct packed {
        logic alloc;
        logic wipe;
        logic release_rx;
        logic free_named;
        logic enq;
    } pba_cmd_t;

    function automatic pba_cmd_t pba_decode(input logic [2:0] op);
        pba_cmd_t c;
        c = '0;
        case (op)
            OP_ALLOC:   c.alloc      = 1'b1;
            OP_WIPE:    c.wipe       = 1'b1;
            OP_RELEASE: c.release_rx = 1'b1;
            OP_FREE:    c.free_named = 1'b1;
            OP_QUEUE:   c.enq        = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic logic pba_known(input logic [2:0] op);
        return (op >= OP_ALLOC) && (op <= OP_QUEUE);
    endfunction

endpackage

// File: rtl/pba_cmd_seq.sv
module pba_cmd_seq
    import pba_pkg::*;
#(
    parameter int BUSY_CYCLES = 3,
    localparam int BW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output pba_cmd_t   cmd,
    output logic       fire,
    output logic       busy
);

    logic [BW-1:0] left_q;

    assign busy = (left_q != '0);
    assign fire = cmd_valid && !busy && pba_known(cmd_op);
    assign cmd  = fire ? pba_decode(cmd_op) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= BW'(BUSY_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - BW'(1);
        end
    end

    // R3: an accepted command holds busy in the following cycle
    p_busy_after_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> busy);

    // R2: a held command is never taken while busy
    p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> $stable(left_q) || (left_q == $past(left_q) - BW'(1)));

endmodule

// File: rtl/pba_slot_pool.sv
module pba_slot_pool #(
    parameter int NUM_SLOTS      = 4,
    parameter int PAGES_PER_SLOT = 8,
    parameter int REQ_W          = 4,
    localparam int PKT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             alloc,
    input  logic [REQ_W-1:0] req_pages,
    input  logic             free_en,
    input  logic [PKT_W-1:0] free_idx,
    output logic             grant_ok,
    output logic [PKT_W-1:0] grant_idx,
    output logic [CNT_W-1:0] free_count
);

    logic [NUM_SLOTS-1:0] used_q;
    logic                 any_free;
    logic                 size_ok;

    always_comb begin
        grant_idx = '0;
        any_free  = 1'b0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!used_q[i]) begin
                grant_idx = PKT_W'(i);
                any_free  = 1'b1;
            end
        end
    end

    always_comb begin
        free_count = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!used_q[i]) free_count = free_count + CNT_W'(1);
        end
    end

    assign size_ok  = ({1'b0, req_pages} < (REQ_W+1)'(PAGES_PER_SLOT));
    assign grant_ok = alloc && any_free && size_ok;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            used_q <= '0;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (free_en && (free_idx == PKT_W'(i))) used_q[i] <= 1'b0;
                else if (grant_ok && (grant_idx == PKT_W'(i))) used_q[i] <= 1'b1;
            end
        end
    end

    // R7: free count never exceeds the number of slots
    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        free_count <= CNT_W'(NUM_SLOTS));

    // R4: a grant consumes exactly one slot
    p_grant_takes_r4: assert property (@(posedge clk) disable iff (rst)
        (grant_ok && !wipe && !free_en) |=> free_count == $past(free_count) - CNT_W'(1));

endmodule

// File: rtl/pba_pkt_fifo.sv
module pba_pkt_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);

    logic [W-1:0]  mem_q [DEPTH];
    logic [IW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
    endfunction

    assign empty   = (cnt_q == '0);
    assign head    = mem_q[rd_q];
    assign push_ok = push && (cnt_q < CW'(DEPTH));
    assign pop_ok  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) begin
                mem_q[wr_q] <= push_data;
                wr_q        <= step(wr_q);
            end
            if (pop_ok) rd_q <= step(rd_q);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8: occupancy stays within depth
    p_fifo_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R9: popping an empty queue without a push leaves it empty
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/pba_top.sv
module pba_top
    import pba_pkg::*;
#(
    parameter int NUM_SLOTS      = 4,
    parameter int PAGES_PER_SLOT = 8,
    parameter int REQ_W          = 4,
    parameter int BUSY_CYCLES    = 3,
    localparam int PKT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [REQ_W-1:0] cmd_pages,
    input  logic [PKT_W-1:0] cmd_pkt,
    input  logic [1:0]       int_ack,
    input  logic             rx_done,
    input  logic [PKT_W-1:0] rx_pkt,
    input  logic             tx_done,
    output logic             busy,
    output logic [PKT_W-1:0] alloc_pkt,
    output logic             alloc_fail,
    output logic             alloc_int,
    output logic             tx_int,
    output logic [CNT_W-1:0] free_units,
    output logic             rx_empty,
    output logic [PKT_W-1:0] rx_head,
    output logic             tx_empty,
    output logic [PKT_W-1:0] tx_head
);

    pba_cmd_t         cmd;
    logic             fire;
    logic             grant_ok;
    logic [PKT_W-1:0] grant_idx;
    logic             free_en;
    logic [PKT_W-1:0] free_idx;
    logic             tx_pop;

    pba_cmd_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd(cmd), .fire(fire), .busy(busy)
    );

    // release frees the receive head, free-named frees the given slot
    assign free_en  = (cmd.release_rx && !rx_empty) || cmd.free_named;
    assign free_idx = cmd.release_rx ? rx_head : cmd_pkt;

    pba_slot_pool #(
        .NUM_SLOTS(NUM_SLOTS), .PAGES_PER_SLOT(PAGES_PER_SLOT), .REQ_W(REQ_W)
    ) u_pool (
        .clk(clk), .rst(rst), .wipe(cmd.wipe), .alloc(cmd.alloc),
        .req_pages(cmd_pages), .free_en(free_en), .free_idx(free_idx),
        .grant_ok(grant_ok), .grant_idx(grant_idx), .free_count(free_units)
    );

    pba_pkt_fifo #(.DEPTH(NUM_SLOTS), .W(PKT_W)) u_rxq (
        .clk(clk), .rst(rst), .clear(cmd.wipe),
        .push(rx_done && !cmd.wipe), .push_data(rx_pkt),
        .pop(cmd.release_rx), .empty(rx_empty), .head(rx_head)
    );

    assign tx_pop = tx_done && !cmd.wipe;

    pba_pkt_fifo #(.DEPTH(NUM_SLOTS), .W(PKT_W)) u_txq (
        .clk(clk), .rst(rst), .clear(cmd.wipe),
        .push(cmd.enq), .push_data(cmd_pkt),
        .pop(tx_pop), .empty(tx_empty), .head(tx_head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_pkt  <= '0;
            alloc_fail <= 1'b0;
            alloc_int  <= 1'b0;
            tx_int     <= 1'b0;
        end else begin
            if (cmd.alloc) begin
                if (grant_ok) begin
                    alloc_pkt  <= grant_idx;
                    alloc_fail <= 1'b0;
                end else begin
                    alloc_fail <= 1'b1;
                end
            end
            alloc_int <= (alloc_int && !int_ack[0]) || grant_ok;
            tx_int    <= (tx_int && !int_ack[1]) || (tx_pop && !tx_empty);
        end
    end

    // R4: a granted allocation raises the interrupt flag and clears failure
    p_alloc_int_r4: assert property (@(posedge clk) disable iff (rst)
        grant_ok |=> (alloc_int && !alloc_fail));

    // R5: a refused allocation keeps the slot count and the interrupt untouched
    p_fail_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.alloc && !grant_ok && !int_ack[0]) |=>
            (alloc_fail && $stable(free_units) && $stable(alloc_int)));

    // R12: reset-all leaves every slot free and both queues empty
    p_wipe_clears_r12: assert property (@(posedge clk) disable iff (rst)
        cmd.wipe |=> (free_units == CNT_W'(NUM_SLOTS) && rx_empty && tx_empty));

    // R11: transmit completion on a filled queue sets the flag
    p_tx_int_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_pop && !tx_empty) |=> tx_int);

    // R2: only one command kind is decoded at a time
    p_one_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd) && (fire == (cmd != '0)));

endmodule

// File: tb/sim_pba_top.sv
`timescale 1ns/1ps
module sim_pba_top;

    localparam int N     = 4;
    localparam int PPS   = 8;
    localparam int BUSYC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [3:0] cmd_pages = '0;
    logic [1:0] cmd_pkt = '0;
    logic [1:0] int_ack = '0;
    logic       rx_done = 1'b0;
    logic [1:0] rx_pkt = '0;
    logic       tx_done = 1'b0;
    logic       busy, alloc_fail, alloc_int, tx_int, rx_empty, tx_empty;
    logic [1:0] alloc_pkt, rx_head, tx_head;
    logic [2:0] free_units;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pba_top u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pages(cmd_pages), .cmd_pkt(cmd_pkt), .int_ack(int_ack),
        .rx_done(rx_done), .rx_pkt(rx_pkt), .tx_done(tx_done),
        .busy(busy), .alloc_pkt(alloc_pkt), .alloc_fail(alloc_fail),
        .alloc_int(alloc_int), .tx_int(tx_int), .free_units(free_units),
        .rx_empty(rx_empty), .rx_head(rx_head), .tx_empty(tx_empty),
        .tx_head(tx_head)
    );

    // behavioural reference
    bit m_used [N];
    int m_rxq[$];
    int m_txq[$];
    int m_pkt, m_fail, m_aint, m_tint, m_busy;
    int pre_rx, pre_tx, pick;
    bit acc, set_a, set_t;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_used[i]) m_used[i] = 0;
            m_rxq.delete(); m_txq.delete();
            m_pkt = 0; m_fail = 0; m_aint = 0; m_tint = 0; m_busy = 0;
        end else begin
            acc = cmd_valid && (m_busy == 0) && (cmd_op >= 1) && (cmd_op <= 5);
            pre_rx = m_rxq.size(); pre_tx = m_txq.size();
            set_a = 0; set_t = 0;
            if (acc && cmd_op == 2) begin
                foreach (m_used[i]) m_used[i] = 0;
                m_rxq.delete(); m_txq.delete();
            end else begin
                if (tx_done && pre_tx > 0) begin void'(m_txq.pop_front()); set_t = 1; end
                if (acc && cmd_op == 5 && pre_tx < N) m_txq.push_back(int'(cmd_pkt));
                if (acc && cmd_op == 3 && pre_rx > 0) begin
                    m_used[m_rxq[0]] = 0;
                    void'(m_rxq.pop_front());
                end
                if (rx_done && pre_rx < N) m_rxq.push_back(int'(rx_pkt));
                if (acc && cmd_op == 4) m_used[cmd_pkt] = 0;
                if (acc && cmd_op == 1) begin
                    pick = -1;
                    for (int i = N - 1; i >= 0; i--) if (!m_used[i]) pick = i;
                    if (pick < 0 || int'(cmd_pages) >= PPS) m_fail = 1;
                    else begin
                        m_used[pick] = 1; m_pkt = pick; m_fail = 0; set_a = 1;
                    end
                end
            end
            m_aint = (set_a || (m_aint != 0 && !int_ack[0])) ? 1 : 0;
            m_tint = (set_t || (m_tint != 0 && !int_ack[1])) ? 1 : 0;
            m_busy = acc ? BUSYC : (m_busy > 0 ? m_busy - 1 : 0);
        end
    end

    function automatic int m_free();
        int f = 0;
        foreach (m_used[i]) if (!m_used[i]) f++;
        return f;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk("R3", "busy", int'(busy), int'(m_busy != 0));
            chk("R4", "alloc_pkt", int'(alloc_pkt), m_pkt);
            chk("R5", "alloc_fail", int'(alloc_fail), m_fail);
            chk("R6", "alloc_int", int'(alloc_int), m_aint);
            chk("R11", "tx_int", int'(tx_int), m_tint);
            chk("R7", "free_units", int'(free_units), m_free());
            chk("R8", "rx_empty", int'(rx_empty), int'(m_rxq.size() == 0));
            if (m_rxq.size() > 0) chk("R8", "rx_head", int'(rx_head), m_rxq[0]);
            chk("R11", "tx_empty", int'(tx_empty), int'(m_txq.size() == 0));
            if (m_txq.size() > 0) chk("R11", "tx_head", int'(tx_head), m_txq[0]);
        end
    end

    task automatic issue(input int op, input int pages, input int pkt);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pages = 4'(pages); cmd_pkt = 2'(pkt);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_rx(input int pkt);
        rx_done = 1'b1; rx_pkt = 2'(pkt);
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset free_units", int'(free_units), 4);
        chk("R1", "reset flags", int'({busy, alloc_fail, alloc_int, tx_int}), 0);
        chk("R1", "reset queues", int'({rx_empty, tx_empty}), 3);

        issue(1, 0, 0);
        chk("R4", "first slot", int'(alloc_pkt), 0);
        issue(1, 7, 0);
        chk("R4", "second slot", int'(alloc_pkt), 1);
        issue(1, 8, 0);
        chk("R5", "oversize fail", int'(alloc_fail), 1);
        chk("R5", "oversize keeps count", int'(free_units), 2);
        int_ack = 2'b01; @(negedge clk); int_ack = 2'b00;
        chk("R6", "ack clears", int'(alloc_int), 0);
        issue(1, 3, 0);
        issue(1, 5, 0);
        issue(1, 0, 0);
        chk("R5", "full fail", int'(alloc_fail), 1);
        chk("R5", "full keeps slot", int'(alloc_pkt), 3);
        issue(4, 0, 1);
        chk("R10", "free named", int'(free_units), 1);
        issue(4, 0, 1);
        chk("R10", "free twice", int'(free_units), 1);
        issue(1, 2, 0);
        chk("R4", "reuse lowest", int'(alloc_pkt), 1);

        pulse_rx(2);
        chk("R8", "rx push", int'({rx_empty, rx_head}), 2);
        issue(3, 0, 0);
        chk("R9", "release frees head", int'(free_units), 1);
        issue(3, 0, 0);
        chk("R9", "release empty", int'(free_units), 1);

        issue(5, 0, 3);
        chk("R11", "enqueue", int'({tx_empty, tx_head}), 3);
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        chk("R11", "tx done", int'({tx_empty, tx_int}), 3);

        issue(4, 0, 0);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_pages = '0;
        @(negedge clk); cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        chk("R2", "cmd while busy ignored", int'(free_units), 2);
        cmd_valid = 1'b1; cmd_op = 3'd7;
        @(negedge clk); cmd_valid = 1'b0;
        chk("R2", "unknown code", int'({busy, free_units}), 2);

        pulse_rx(1);
        issue(5, 0, 2);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; rx_done = 1'b1; rx_pkt = 2'd3; tx_done = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; rx_done = 1'b0; tx_done = 1'b0;
        chk("R12", "reset-all", int'({free_units, rx_empty, tx_empty}), 19);
        chk("R12", "flags kept", int'(tx_int), 1);

        for (int k = 0; k < 4000; k++) begin
            cmd_valid = ($urandom_range(0, 2) == 0);
            cmd_op    = 3'($urandom_range(0, 7) == 2 ? (($urandom_range(0, 3) == 0) ? 2 : 1) : $urandom_range(0, 7));
            cmd_pages = 4'($urandom_range(0, 9));
            cmd_pkt   = 2'($urandom_range(0, 3));
            int_ack   = 2'($urandom_range(0, 3) == 0 ? $urandom_range(0, 3) : 0);
            rx_done   = ($urandom_range(0, 4) == 0);
            rx_pkt    = 2'($urandom_range(0, 3));
            tx_done   = ($urandom_range(0, 4) == 0);
            @(negedge clk);
        end
        cmd_valid = 1'b0; rx_done = 1'b0; tx_done = 1'b0; int_ack = '0;
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule